// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor core. Each instruction finishes in one clock cycle. In that cycle the core fetches the word at the program counter and reads up to two registers. It then runs one ALU operation, optionally touches data memory, and commits the result. The core executes register arithmetic and logic (add, sub, and, or, slt), word loads and stores, branch-if-equal and an absolute jump. Any other opcode is treated as a no-op.

Decoding is done in two levels. The main decoder turns the 6-bit opcode into datapath select lines and a 2-bit operation class. A second stage turns that class, together with the funct field, into a 3-bit ALU code. A branch is taken only when the branch decode line and the ALU zero flag are both true.

The instruction store and the data store are internal word arrays. A loader port fills them while reset is held. The commit side is brought out at the ports as three views: the register write (enable, index, value), the store (enable, byte address, value) and the current program counter. An enclosing design or a bench uses these views to follow execution.

Top module: `sc_core`

## Requirements
- R1: While rst_n is low, pc_o reads 0 and neither rf_we_o nor dm_we_o is asserted. pc_o is always a multiple of 4.
- R2: Every instruction that is neither a taken beq nor a jump moves pc_o to pc_o + 4 on the next cycle.
- R3: Opcode 000000 is register-format: the value goes to rd = instr[15:11]; the sources are rs = instr[25:21] and rt = instr[20:16]. The funct field instr[5:0] selects the operation: 100000 is add, 100010 is sub (rs minus rt), 100100 is and, 100101 is or, and 101010 is slt.
- R4: slt writes 1 when rs is less than rt as a signed two's-complement number, and writes 0 otherwise.
- R5: Opcode 100011 (load) reads the data word at byte address rs plus the sign-extended instr[15:0] and writes that word to rt.
- R6: Opcode 101011 (store) writes rt to the data word at byte address rs plus the sign-extended instr[15:0]. It does not write any register.
- R7: Opcode 000100 (beq) is taken only when rs equals rt. The target is pc+4 plus the sign-extended instr[15:0] shifted left by 2, and a negative offset is allowed. When the branch is not taken, the PC advances by 4. beq writes nothing.
- R8: Opcode 000010 (jump) loads the PC with {pc+4 [31:28], instr[25:0], 2'b00}. It writes nothing.
- R9: Register 0 always reads as zero, and a write aimed at it produces no commit.
- R10: Any opcode other than the five listed above writes no register and no memory, and moves the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| ld_en | input | 1 | Loader write strobe |
| ld_sel | input | 1 | Loader target: 0 selects the instruction store, 1 selects the data store |
| ld_addr | input | LD_AW | Loader word index |
| ld_data | input | 32 | Loader word |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register commit this cycle (never for register 0) |
| rf_waddr_o | output | 5 | Register being written |
| rf_wdata_o | output | 32 | Value being written |
| dm_we_o | output | 1 | Store commit this cycle |
| dm_addr_o | output | 32 | Store byte address |
| dm_wdata_o | output | 32 | Store value |

## Verification
The bench uses the default build: IMEM_AW = 6 and DMEM_AW = 6, which gives 64 instruction words and 64 data words. This depth holds a 23-word program and still leaves data words free at both positive and negative offsets from a base register. The program exercises both directions of the signed compare, a store followed by a reload, and a taken forward branch as well as a failed one. It also contains a jump over a word, an undefined opcode, a write aimed at register 0, and a backward self-branch that parks the core at a known PC.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam int XLEN = 32;
  localparam int RIDX_W = 5;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10
  } alu_cls_e;

  localparam logic [5:0] OPC_REG   = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef struct packed {
    logic     dst_rd;
    logic     reg_wr;
    logic     b_imm;
    logic     mem_rd;
    logic     mem_wr;
    logic     wb_mem;
    logic     is_beq;
    logic     is_jmp;
    alu_cls_e cls;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_core_ctrl
  import sc_core_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_op_e    alu_op
);
  // first level: opcode only
  always_comb begin
    ctrl = '{dst_rd: 1'b0, reg_wr: 1'b0, b_imm: 1'b0, mem_rd: 1'b0,
             mem_wr: 1'b0, wb_mem: 1'b0, is_beq: 1'b0, is_jmp: 1'b0,
             cls: CLS_ADD};
    case (opcode)
      OPC_REG: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_wr = 1'b1;
        ctrl.cls    = CLS_FUNCT;
      end
      OPC_LOAD: begin
        ctrl.reg_wr = 1'b1;
        ctrl.b_imm  = 1'b1;
        ctrl.mem_rd = 1'b1;
        ctrl.wb_mem = 1'b1;
      end
      OPC_STORE: begin
        ctrl.b_imm  = 1'b1;
        ctrl.mem_wr = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.is_beq = 1'b1;
        ctrl.cls    = CLS_SUB;
      end
      OPC_JUMP: ctrl.is_jmp = 1'b1;
      default: ;
    endcase
  end

  // second level: class refined by funct
  always_comb begin
    alu_op = ALU_ADD;
    case (ctrl.cls)
      CLS_SUB: alu_op = ALU_SUB;
      CLS_FUNCT: begin
        case (funct)
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_SLT:  alu_op = ALU_SLT;
          default: alu_op = ALU_ADD;
        endcase
      end
      default: alu_op = ALU_ADD;
    endcase
  end

  AST_ONE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl.reg_wr, ctrl.mem_wr, ctrl.is_beq, ctrl.is_jmp})); // R10
  AST_LOAD_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.wb_mem |-> (ctrl.mem_rd && ctrl.b_imm && !ctrl.mem_wr)); // R5
endmodule

// File: rtl/sc_alu.sv
module sc_core_alu
  import sc_core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_core_regfile #(
  parameter int AW = 5,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  localparam int NREG = 1 << AW;

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  localparam int LD_AW = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic              ld_sel,
  input  logic [LD_AW-1:0]  ld_addr,
  input  logic [XLEN-1:0]   ld_data,
  output logic [XLEN-1:0]   pc_o,
  output logic              rf_we_o,
  output logic [RIDX_W-1:0] rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic              dm_we_o,
  output logic [XLEN-1:0]   dm_addr_o,
  output logic [XLEN-1:0]   dm_wdata_o
);
  localparam int IWORDS = 1 << IMEM_AW;
  localparam int DWORDS = 1 << DMEM_AW;

  // reset release synchronizer
  logic [1:0] rel_q;
  logic       run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= 2'b00;
    else        rel_q <= {rel_q[0], 1'b1};
  end
  assign run = rel_q[1];

  // program counter
  logic [XLEN-1:0] pc_q, pc_d, pc4, br_tgt, jmp_tgt;
  logic            take;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pc_q <= '0;
    else if (run) pc_q <= pc_d;
  end

  // instruction store
  logic [XLEN-1:0] imem [IWORDS];
  logic [XLEN-1:0] instr;
  always_ff @(posedge clk) begin
    if (ld_en && !ld_sel) imem[ld_addr[IMEM_AW-1:0]] <= ld_data;
  end
  assign instr = imem[pc_q[IMEM_AW+1:2]];

  // decode
  logic [RIDX_W-1:0] rs, rt, rd;
  logic [XLEN-1:0]   sext;
  ctrl_t             ctrl;
  alu_op_e           alu_op;
  assign rs   = instr[25:21];
  assign rt   = instr[20:16];
  assign rd   = instr[15:11];
  assign sext = {{(XLEN-16){instr[15]}}, instr[15:0]};

  sc_core_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl),
    .alu_op (alu_op)
  );

  // register file
  logic [XLEN-1:0]   rd1, rd2, wb_data;
  logic [RIDX_W-1:0] wb_idx;
  logic              wb_en;
  sc_core_regfile #(.AW(RIDX_W), .W(XLEN)) u_rf (
    .clk   (clk),
    .we    (wb_en),
    .waddr (wb_idx),
    .wdata (wb_data),
    .ra1   (rs),
    .ra2   (rt),
    .rd1   (rd1),
    .rd2   (rd2)
  );

  // ALU
  logic [XLEN-1:0] alu_b, alu_y;
  logic            alu_z;
  assign alu_b = ctrl.b_imm ? sext : rd2;
  sc_core_alu #(.W(XLEN)) u_alu (
    .a    (rd1),
    .b    (alu_b),
    .op   (alu_op),
    .y    (alu_y),
    .zero (alu_z)
  );

  // data store
  logic [XLEN-1:0]    dmem [DWORDS];
  logic [DMEM_AW-1:0] d_idx;
  logic [XLEN-1:0]    d_rd;
  logic               d_we;
  assign d_idx = alu_y[DMEM_AW+1:2];
  assign d_we  = ctrl.mem_wr && run;
  always_ff @(posedge clk) begin
    if (ld_en && ld_sel) dmem[ld_addr[DMEM_AW-1:0]] <= ld_data;
    else if (d_we)       dmem[d_idx] <= rd2;
  end
  assign d_rd = ctrl.mem_rd ? dmem[d_idx] : '0;

  // write-back
  assign wb_idx  = ctrl.dst_rd ? rd : rt;
  assign wb_data = ctrl.wb_mem ? d_rd : alu_y;
  assign wb_en   = ctrl.reg_wr && run;

  // next PC
  assign pc4     = pc_q + 32'd4;
  assign br_tgt  = pc4 + (sext << 2);
  assign jmp_tgt = {pc4[31:28], instr[25:0], 2'b00};
  assign take    = ctrl.is_beq && alu_z;
  always_comb begin
    if (ctrl.is_jmp) pc_d = jmp_tgt;
    else if (take)   pc_d = br_tgt;
    else             pc_d = pc4;
  end

  assign pc_o       = pc_q;
  assign rf_we_o    = wb_en && (wb_idx != '0);
  assign rf_waddr_o = wb_idx;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = d_we;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rd2;

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[1:0] == 2'b00); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !take && !ctrl.is_jmp) |=> (pc_q == $past(pc_q) + 32'd4)); // R2
  AST_TAKEN_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (rd1 == rd2)); // R7
  AST_SLT_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
    (run && alu_op == ALU_SLT) |-> (alu_y[XLEN-1:1] == '0)); // R4
  AST_R0_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rs == '0) |-> (rd1 == '0)); // R9
endmodule

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;
  localparam int LD_AW = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ld_en = 1'b0;
  logic             ld_sel = 1'b0;
  logic [LD_AW-1:0] ld_addr = '0;
  logic [31:0]      ld_data = '0;
  logic [31:0]      pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [4:0]       rf_waddr_o;
  logic             rf_we_o, dm_we_o;

  always #4 clk = ~clk;

  sc_core u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_en      (ld_en),
    .ld_sel     (ld_sel),
    .ld_addr    (ld_addr),
    .ld_data    (ld_data),
    .pc_o       (pc_o),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .rf_wdata_o (rf_wdata_o),
    .dm_we_o    (dm_we_o),
    .dm_addr_o  (dm_addr_o),
    .dm_wdata_o (dm_wdata_o)
  );

  typedef struct {
    bit          is_mem;
    logic [31:0] addr;
    logic [31:0] data;
    string       req;
  } item_t;

  item_t q[$];
  int    errors = 0;
  int    checks = 0;
  bit    done = 0;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic load(bit sel, int idx, logic [31:0] w);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_addr = LD_AW'(idx); ld_data = w;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic expect_wr(bit m, logic [31:0] a, logic [31:0] d, string r);
    item_t it;
    it.is_mem = m; it.addr = a; it.data = d; it.req = r;
    q.push_back(it);
  endtask

  task automatic check(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // monitor: compare each commit against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done && (rf_we_o || dm_we_o)) begin
      if (q.size() == 0) begin
        check(0, "unexpected commit", rf_we_o ? {27'd0, rf_waddr_o} : dm_addr_o, 32'hx);
      end else begin
        item_t it;
        it = q.pop_front();
        if (it.is_mem) begin
          check(dm_we_o && !rf_we_o && dm_addr_o == it.addr, {it.req, " store addr"}, dm_addr_o, it.addr);
          check(dm_wdata_o == it.data, {it.req, " store data"}, dm_wdata_o, it.data);
        end else begin
          check(rf_we_o && !dm_we_o && rf_waddr_o == it.addr[4:0], {it.req, " reg index"},
                {27'd0, rf_waddr_o}, it.addr);
          check(rf_wdata_o == it.data, {it.req, " reg data"}, rf_wdata_o, it.data);
        end
      end
    end
  end

  initial begin
    logic [31:0] prog [23];
    // data words: 5, 7, -16, 0x80000000
    prog[0]  = enc_i(6'b100011, 0, 1, 0);     // lw r1,0(r0)
    prog[1]  = enc_i(6'b100011, 0, 2, 4);     // lw r2,4(r0)
    prog[2]  = enc_i(6'b100011, 0, 3, 8);     // lw r3,8(r0)
    prog[3]  = enc_r(1, 2, 4, 6'b100000);     // add
    prog[4]  = enc_r(1, 2, 5, 6'b100010);     // sub
    prog[5]  = enc_r(1, 2, 6, 6'b100100);     // and
    prog[6]  = enc_r(1, 2, 7, 6'b100101);     // or
    prog[7]  = enc_r(3, 1, 8, 6'b101010);     // slt -16<5
    prog[8]  = enc_r(1, 3, 9, 6'b101010);     // slt 5<-16
    prog[9]  = enc_r(1, 2, 0, 6'b100000);     // write to r0
    prog[10] = enc_i(6'b101011, 0, 4, 16);    // sw r4,16(r0)
    prog[11] = enc_i(6'b100011, 0, 10, 16);   // lw r10,16(r0)
    prog[12] = enc_i(6'b000100, 1, 2, 5);     // beq not taken
    prog[13] = enc_i(6'b000100, 6, 1, 2);     // beq taken -> 16
    prog[14] = enc_r(1, 1, 11, 6'b100000);    // skipped
    prog[15] = enc_r(1, 1, 12, 6'b100000);    // skipped
    prog[16] = enc_i(6'b101011, 4, 7, -4);    // sw r7,-4(r4)
    prog[17] = enc_i(6'b100011, 4, 14, -4);   // lw r14,-4(r4)
    prog[18] = {6'b000010, 26'd20};           // j 20
    prog[19] = enc_r(1, 1, 15, 6'b100000);    // skipped
    prog[20] = enc_i(6'b001000, 1, 20, 3);    // undefined opcode
    prog[21] = enc_r(0, 0, 16, 6'b100000);    // r16 = r0 + r0
    prog[22] = enc_i(6'b000100, 0, 0, -1);    // self loop at 88

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 23; i++) load(1'b0, i, prog[i]);
    load(1'b1, 0, 32'd5);
    load(1'b1, 1, 32'd7);
    load(1'b1, 2, 32'hFFFF_FFF0);
    load(1'b1, 3, 32'h8000_0000);
    @(negedge clk);
    check(pc_o == 32'd0, "R1 reset pc", pc_o, 32'd0);
    check(!rf_we_o && !dm_we_o, "R1 no commit in reset", {30'd0, rf_we_o, dm_we_o}, 32'd0);

    expect_wr(0, 1,  32'd5,          "R5 load");
    expect_wr(0, 2,  32'd7,          "R5 load");
    expect_wr(0, 3,  32'hFFFF_FFF0,  "R5 load");
    expect_wr(0, 4,  32'd12,         "R3 add");
    expect_wr(0, 5,  32'hFFFF_FFFE,  "R3 sub");
    expect_wr(0, 6,  32'd5,          "R3 and");
    expect_wr(0, 7,  32'd7,          "R3 or");
    expect_wr(0, 8,  32'd1,          "R4 slt true");
    expect_wr(0, 9,  32'd0,          "R4 slt false");
    expect_wr(1, 16, 32'd12,         "R6 store after R9 r0 write");
    expect_wr(0, 10, 32'd12,         "R5 reload");
    expect_wr(1, 8,  32'd7,          "R7 taken branch then R6 negative offset");
    expect_wr(0, 14, 32'd7,          "R5 negative offset");
    expect_wr(0, 16, 32'd0,          "R8 jump R10 no-op R9 zero");

    @(negedge clk);
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
    check(pc_o == 32'd88, "R2 R7 R8 parked pc", pc_o, 32'd88);
    check(q.size() == 0, "R7 R10 all commits seen", 32'(q.size()), 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule